// File: doc/BRIEF.md
# Touch Digitiser Conversion Sequencer

This block runs the conversions of a resistive touch-panel digitiser. A host write with the poll bit set asks for one sample on a chosen channel (X, Y or pressure). The block then drives the plate switch matrix and waits out a settling time, counted in link-frame strobes and picked from a non-linear table by a 4-bit code. It honours a mask pin that can freeze, delay or trigger the sequence, and pulses an ADC start. After a fixed conversion latency it captures the ADC result into the readback fields and clears the busy bit.

The readback fields hold the result, the channel that was actually converted and the pen-down state at the moment of capture. A host that compares the echoed channel with its request can reject a stale sample. Pen-detect gating withholds completion while the pen is up, so the host sees a timeout. A continuous mode repeats conversions after a programmed gap and marks each result with a programmed link slot number, with no poll writes needed.

Top module: `touch_conv_seq`

## Requirements
- R1: After reset, pollBusy, adcStart, driveOn and slotValid are low, and rdResult, rdChan and rdPenDown are zero.
- R2: A pollWr pulse is accepted only when the sequencer is idle and contEn is low. pollBusy is high from the next cycle. pollBusy stays high for exactly S+3 frameTick strobes, counted from the cycle after the write. S is the settle length for wrDelayCode: codes 0..14 give 1, 2, 4, 8, 16, 32, 48, 64, 96, 128, 160, 192, 224, 256 and 288 frames.
- R3: Code 15 gives no settling wait, so a poll lasts 3 strobes. driveOn is high while a conversion is under way. After a conversion that used code 15, driveOn stays high; after one that used any other code, it goes low.
- R4: With maskMode 0 the mask pin has no effect on timing.
- R5: With maskMode 1 the sequence is frozen while the synchronised mask pin is high: strobes seen during that time are not counted in either settling or conversion.
- R6: With maskMode 2, a rising edge on the mask pin during settling restarts the settle count at its full length.
- R7: With maskMode 3, an accepted request waits, busy, for a rising edge on the mask pin, and only then starts settling. The total is the strobes before the edge plus S+3.
- R8: On completion, rdResult takes adcResult, rdChan takes the channel latched at the request (01 X, 10 Y, 11 pressure) and rdPenDown takes the synchronised pen input. These fields change only on a frameTick cycle.
- R9: A pollWr during a conversion in progress is ignored: neither the channel nor the timing of the running conversion changes.
- R10: A pressure request (wrChanSel 11) while presCurrent is 00 is ignored. With presCurrent 01 or 10 it is accepted.
- R11: With penGateEn high and the pen up, the final conversion strobe does not complete and pollBusy stays set. Completion occurs on the first strobe after the pen is seen down.
- R12: While contEn is high, conversions repeat with contRate+1 gap strobes plus S+3 strobes between results. Each result gives a one-cycle slotValid pulse with slotOut equal to contSlot. pollBusy stays low and pollWr is ignored.
- R13: adcStart is a one-cycle pulse at the end of settling. Completion follows exactly 3 strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle strobe per link frame |
| pollWr | input | 1 | Write strobe with the poll bit set |
| wrChanSel | input | 2 | Requested channel: 01 X, 10 Y, 11 pressure |
| wrDelayCode | input | 4 | Settle-delay code |
| maskMode | input | 2 | 0 ignore, 1 level freeze, 2 edge restart, 3 edge trigger |
| presCurrent | input | 2 | Pressure current setting: 00 off, 01 low, 10 high |
| penGateEn | input | 1 | Withhold completion while the pen is up |
| contEn | input | 1 | Continuous conversion mode |
| contRate | input | RATE_W | Gap between continuous conversions, in strobes minus one |
| contSlot | input | SLOT_W | Link slot tagged on continuous results |
| maskPin | input | 1 | Asynchronous mask input |
| penDetect | input | 1 | Asynchronous pen-down comparator input |
| adcResult | input | RES_W | ADC data at completion |
| pollBusy | output | 1 | Poll bit readback |
| adcStart | output | 1 | ADC start pulse |
| driveOn | output | 1 | Switch-matrix drive enable |
| rdResult | output | RES_W | Captured result |
| rdChan | output | 2 | Echoed channel of the last sample |
| rdPenDown | output | 1 | Pen state at capture |
| slotValid | output | 1 | Continuous result pulse |
| slotOut | output | SLOT_W | Slot number of that result |

## Verification
The assertions assume that frameTick is a one-cycle pulse with several idle cycles between strobes. They also assume that the configuration inputs stay still while a request is pending, and that the mask and pen inputs change well clear of a strobe, so that the synchroniser delay never straddles one. The stimulus drives every input on the falling edge and generates strobes every eight cycles. It moves the mask and pen pins three cycles after a strobe, and it changes mode fields only while the block is idle.

// File: rtl/tds_pkg.sv
package tds_pkg;
  localparam int SETTLE_W = 9;
  localparam logic [1:0] CH_PRES = 2'b11;
  localparam logic [3:0] CODE_NOWAIT = 4'd15;

  typedef enum logic [1:0] {
    MASK_OFF = 2'd0, MASK_LEVEL = 2'd1, MASK_EDGE_DELAY = 2'd2, MASK_EDGE_START = 2'd3
  } mask_mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_SETTLE, S_CONV, S_GAP
  } seq_state_t;

  typedef struct packed {
    logic start;     // sequence launched this cycle
    logic fromCont;  // running sequence came from continuous mode
    logic capture;   // result is taken this cycle
    logic active;    // matrix must be driven
  } seq_strobe_t;

  function automatic logic [SETTLE_W-1:0] settleFrames(input logic [3:0] code);
    logic [SETTLE_W-1:0] f;
    case (code)
      4'd0: f = 9'd1;    4'd1: f = 9'd2;    4'd2: f = 9'd4;    4'd3: f = 9'd8;
      4'd4: f = 9'd16;   4'd5: f = 9'd32;   4'd6: f = 9'd48;   4'd7: f = 9'd64;
      4'd8: f = 9'd96;   4'd9: f = 9'd128;  4'd10: f = 9'd160; 4'd11: f = 9'd192;
      4'd12: f = 9'd224; 4'd13: f = 9'd256; 4'd14: f = 9'd288;
      default: f = 9'd0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/tds_sync.sv
module tds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], asyncIn};
  end
  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/tds_ctrl.sv
module tds_ctrl
  import tds_pkg::*;
#(
  parameter int RATE_W      = 3,
  parameter int CONV_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameTick,
  input  logic              pollWr,
  input  logic [1:0]        wrChanSel,
  input  logic [3:0]        wrDelayCode,
  input  logic [1:0]        maskMode,
  input  logic [1:0]        presCurrent,
  input  logic              penGateEn,
  input  logic              contEn,
  input  logic [RATE_W-1:0] contRate,
  input  logic              maskSync,
  input  logic              penSync,
  output seq_strobe_t       strobe,
  output logic              pollBusy,
  output logic              adcStart,
  output logic              seqIdle
);
  localparam int CONV_W = $clog2(CONV_FRAMES + 1);
  localparam int GAP_W  = RATE_W + 1;

  seq_state_t           state, startState;
  logic [SETTLE_W-1:0]  settleCnt;
  logic [CONV_W-1:0]    convCnt;
  logic [GAP_W-1:0]     gapCnt;
  logic [3:0]           codeQ;
  logic contRun, maskPrev, busyQ, startQ;
  logic maskRise, freeze, pollOk, gapDone, penOk, captureNow, seqStart;

  assign maskRise   = maskSync & ~maskPrev;
  assign freeze     = (maskMode == MASK_LEVEL) && maskSync;
  assign pollOk     = pollWr && (state == S_IDLE) && !contEn &&
                      !((wrChanSel == CH_PRES) && (presCurrent == 2'b00));
  assign gapDone    = (state == S_GAP) && contEn && frameTick && (gapCnt == GAP_W'(1));
  assign penOk      = !penGateEn || penSync;
  assign captureNow = (state == S_CONV) && frameTick && !freeze &&
                      (convCnt == CONV_W'(1)) && penOk;
  assign seqStart   = pollOk || gapDone;

  always_comb begin
    if (maskMode == MASK_EDGE_START)      startState = S_ARM;
    else if (wrDelayCode == CODE_NOWAIT)  startState = S_CONV;
    else                                  startState = S_SETTLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; settleCnt <= '0; convCnt <= '0; gapCnt <= '0;
      codeQ <= '0; contRun <= 1'b0; maskPrev <= 1'b0; busyQ <= 1'b0; startQ <= 1'b0;
    end else begin
      maskPrev <= maskSync;
      startQ   <= 1'b0;
      case (state)
        S_IDLE: if (contEn) begin
          state  <= S_GAP;
          gapCnt <= GAP_W'(contRate) + GAP_W'(1);
        end
        S_ARM: if (maskRise) begin
          state     <= (codeQ == CODE_NOWAIT) ? S_CONV : S_SETTLE;
          settleCnt <= settleFrames(codeQ);
          convCnt   <= CONV_W'(CONV_FRAMES);
          startQ    <= (codeQ == CODE_NOWAIT);
        end
        S_SETTLE: begin
          if ((maskMode == MASK_EDGE_DELAY) && maskRise) settleCnt <= settleFrames(codeQ);
          else if (frameTick && !freeze) begin
            if (settleCnt == SETTLE_W'(1)) begin
              state   <= S_CONV;
              convCnt <= CONV_W'(CONV_FRAMES);
              startQ  <= 1'b1;
            end else settleCnt <= settleCnt - SETTLE_W'(1);
          end
        end
        S_CONV: if (frameTick && !freeze) begin
          if (convCnt == CONV_W'(1)) begin
            if (penOk) begin
              busyQ <= 1'b0;
              if (contEn) begin
                state  <= S_GAP;
                gapCnt <= GAP_W'(contRate) + GAP_W'(1);
              end else state <= S_IDLE;
            end
          end else convCnt <= convCnt - CONV_W'(1);
        end
        S_GAP: begin
          if (!contEn) state <= S_IDLE;
          else if (frameTick && (gapCnt != GAP_W'(1))) gapCnt <= gapCnt - GAP_W'(1);
        end
        default: state <= S_IDLE;
      endcase
      if (seqStart) begin
        state     <= startState;
        codeQ     <= wrDelayCode;
        settleCnt <= settleFrames(wrDelayCode);
        convCnt   <= CONV_W'(CONV_FRAMES);
        startQ    <= (startState == S_CONV);
        contRun   <= gapDone;
        if (pollOk) busyQ <= 1'b1;
      end
    end
  end

  assign strobe.start    = seqStart;
  assign strobe.fromCont = contRun;
  assign strobe.capture  = captureNow;
  assign strobe.active   = (state == S_ARM) || (state == S_SETTLE) || (state == S_CONV);
  assign pollBusy = busyQ;
  assign adcStart = startQ;
  assign seqIdle  = (state == S_IDLE);
endmodule

// File: rtl/tds_dpath.sv
module tds_dpath
  import tds_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strobe,
  input  logic [1:0]        wrChanSel,
  input  logic [3:0]        wrDelayCode,
  input  logic [RES_W-1:0]  adcResult,
  input  logic              penSync,
  input  logic [SLOT_W-1:0] contSlot,
  output logic [RES_W-1:0]  rdResult,
  output logic [1:0]        rdChan,
  output logic              rdPenDown,
  output logic              driveOn,
  output logic              slotValid,
  output logic [SLOT_W-1:0] slotOut
);
  logic [1:0] chanQ;
  logic       holdOn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chanQ <= '0; holdOn <= 1'b0; rdResult <= '0; rdChan <= '0;
      rdPenDown <= 1'b0; slotValid <= 1'b0; slotOut <= '0;
    end else begin
      slotValid <= strobe.capture && strobe.fromCont;
      if (strobe.start) begin
        chanQ  <= wrChanSel;
        holdOn <= (wrDelayCode == CODE_NOWAIT);
      end
      if (strobe.capture) begin
        rdResult  <= adcResult;
        rdChan    <= chanQ;
        rdPenDown <= penSync;
        if (strobe.fromCont) slotOut <= contSlot;
      end
    end
  end

  assign driveOn = strobe.active || holdOn;
endmodule

// File: rtl/touch_conv_seq.sv
module touch_conv_seq
  import tds_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int RATE_W      = 3,
  parameter int SLOT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameTick,
  input  logic              pollWr,
  input  logic [1:0]        wrChanSel,
  input  logic [3:0]        wrDelayCode,
  input  logic [1:0]        maskMode,
  input  logic [1:0]        presCurrent,
  input  logic              penGateEn,
  input  logic              contEn,
  input  logic [RATE_W-1:0] contRate,
  input  logic [SLOT_W-1:0] contSlot,
  input  logic              maskPin,
  input  logic              penDetect,
  input  logic [RES_W-1:0]  adcResult,
  output logic              pollBusy,
  output logic              adcStart,
  output logic              driveOn,
  output logic [RES_W-1:0]  rdResult,
  output logic [1:0]        rdChan,
  output logic              rdPenDown,
  output logic              slotValid,
  output logic [SLOT_W-1:0] slotOut
);
  logic maskSync, penSync, seqIdle;
  seq_strobe_t strobe;

  tds_sync #(.STAGES(SYNC_STAGES)) maskSync_i (.clk(clk), .rst_n(rst_n), .asyncIn(maskPin),   .syncOut(maskSync));
  tds_sync #(.STAGES(SYNC_STAGES)) penSync_i  (.clk(clk), .rst_n(rst_n), .asyncIn(penDetect), .syncOut(penSync));

  tds_ctrl #(.RATE_W(RATE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .frameTick(frameTick), .pollWr(pollWr),
    .wrChanSel(wrChanSel), .wrDelayCode(wrDelayCode), .maskMode(maskMode),
    .presCurrent(presCurrent), .penGateEn(penGateEn), .contEn(contEn),
    .contRate(contRate), .maskSync(maskSync), .penSync(penSync),
    .strobe(strobe), .pollBusy(pollBusy), .adcStart(adcStart), .seqIdle(seqIdle)
  );

  tds_dpath #(.RES_W(RES_W), .SLOT_W(SLOT_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrChanSel(wrChanSel),
    .wrDelayCode(wrDelayCode), .adcResult(adcResult), .penSync(penSync),
    .contSlot(contSlot), .rdResult(rdResult), .rdChan(rdChan),
    .rdPenDown(rdPenDown), .driveOn(driveOn), .slotValid(slotValid), .slotOut(slotOut)
  );
endmodule

// File: rtl/touch_conv_seq_chk.sv
module touch_conv_seq_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frameTick,
  input logic             pollWr,
  input logic [1:0]       wrChanSel,
  input logic [1:0]       presCurrent,
  input logic             contEn,
  input logic             seqIdle,
  input logic             pollBusy,
  input logic             adcStart,
  input logic             slotValid,
  input logic [1:0]       rdChan,
  input logic [RES_W-1:0] rdResult
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pollBusy && rdChan == 2'b00 && rdResult == '0));

  p_busy_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pollBusy) |-> $past(pollWr));

  p_done_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pollBusy) |-> $past(frameTick));

  p_result_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdResult) |-> $past(frameTick));

  p_pres_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pollWr && seqIdle && !contEn && wrChanSel == 2'b11 && presCurrent == 2'b00) |=> !pollBusy);

  p_slot_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    slotValid |=> !slotValid);

  p_start_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    adcStart |=> !adcStart);
endmodule

bind touch_conv_seq touch_conv_seq_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frameTick(frameTick), .pollWr(pollWr),
  .wrChanSel(wrChanSel), .presCurrent(presCurrent), .contEn(contEn),
  .seqIdle(seqIdle), .pollBusy(pollBusy), .adcStart(adcStart),
  .slotValid(slotValid), .rdChan(rdChan), .rdResult(rdResult)
);

// File: tb/touch_conv_seq_tb_top.sv
module touch_conv_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, frameTick = 1'b0, pollWr = 1'b0;
  logic [1:0] wrChanSel = 2'b01, maskMode = 2'd0, presCurrent = 2'b01, rdChan;
  logic [3:0] wrDelayCode = 4'd0, contSlot = 4'd0, slotOut;
  logic [2:0] contRate = 3'd0;
  logic penGateEn = 1'b0, contEn = 1'b0, maskPin = 1'b0, penDetect = 1'b1;
  logic [11:0] adcResult = 12'h000, rdResult;
  logic pollBusy, adcStart, driveOn, rdPenDown, slotValid;

  int checks = 0, fails = 0, tickCnt = 0, cycles = 0, phase = 0;
  bit finished = 0;

  touch_conv_seq dut_i (.*);

  always #10 clk = ~clk;  // 50 MHz
  always @(negedge clk) begin
    frameTick <= (phase == 0);
    phase <= (phase + 1) % 8;
  end
  always @(posedge clk) if (frameTick) tickCnt <= tickCnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expFrames(input int code);
    if (code == 15) return 0;
    if (code <= 4) return 1 << code;
    if (code <= 7) return 16 * (code - 3);
    return 32 * (code - 5);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic pulsePoll(input logic [1:0] ch, input logic [3:0] code);
    @(negedge clk); wrChanSel = ch; wrDelayCode = code; pollWr = 1'b1;
    @(negedge clk); pollWr = 1'b0;
  endtask

  task automatic pollStart(input logic [1:0] ch, input logic [3:0] code, output int t0);
    pulsePoll(ch, code);
    t0 = tickCnt;
  endtask

  task automatic waitDone(input int t0, output int ticks, output int nStart, output int doneMinusStart);
    int st = 0;
    nStart = 0;
    for (int i = 0; i < 20000; i++) begin
      if (adcStart) begin nStart++; st = tickCnt; end
      if (!pollBusy) break;
      @(negedge clk);
    end
    ticks = tickCnt - t0;
    doneMinusStart = tickCnt - st;
  endtask

  task automatic waitTicks(input int n);
    int t = tickCnt;
    while (tickCnt < t + n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0, tk, ns, dms;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", pollBusy, 0);   chk("R1 adcStart", adcStart, 0);
    chk("R1 driveOn", driveOn, 0); chk("R1 slotValid", slotValid, 0);
    chk("R1 rdResult", rdResult, 0); chk("R1 rdChan", rdChan, 0);
    chk("R1 rdPenDown", rdPenDown, 0);

    // R2 R3 R8 R13: sweep every delay code in mask mode 0
    for (int code = 0; code < 16; code++) begin
      logic [1:0] ch;
      ch = 2'(code % 3 + 1);
      adcResult = 12'((code * 273 + 17) & 12'hfff);
      pollStart(ch, 4'(code), t0);
      chk("R2 busy after write", pollBusy, 1);
      chk("R3 driveOn while busy", driveOn, 1);
      waitDone(t0, tk, ns, dms);
      chk("R2 poll length", tk, expFrames(code) + 3);
      chk("R13 one start pulse", ns, 1);
      chk("R13 start to done", dms, 3);
      chk("R8 result", rdResult, (code * 273 + 17) & 12'hfff);
      chk("R8 channel echo", rdChan, ch);
      chk("R8 pen flag", rdPenDown, 1);
      chk("R3 driveOn after", driveOn, (code == 15) ? 1 : 0);
    end

    // R4: mode 0 ignores mask pin
    pollStart(2'b01, 4'd3, t0);
    waitTicks(2); maskPin = 1'b1; waitTicks(2); maskPin = 1'b0;
    waitDone(t0, tk, ns, dms);
    chk("R4 mode0 length", tk, 11);

    // R9: second write while busy ignored
    adcResult = 12'h5a5;
    pollStart(2'b01, 4'd4, t0);
    waitTicks(2);
    pulsePoll(2'b10, 4'd0);
    waitDone(t0, tk, ns, dms);
    chk("R9 length unchanged", tk, 19);
    chk("R9 channel unchanged", rdChan, 1);

    // R5: level freeze
    maskMode = 2'd1; maskPin = 1'b1; repeat (4) @(negedge clk);
    pollStart(2'b10, 4'd2, t0);
    waitTicks(5); maskPin = 1'b0;
    waitDone(t0, tk, ns, dms);
    chk("R5 frozen length", tk, 12);

    // R6: edge restart
    maskMode = 2'd2; repeat (4) @(negedge clk);
    pollStart(2'b10, 4'd3, t0);
    waitTicks(3); maskPin = 1'b1;
    waitDone(t0, tk, ns, dms);
    chk("R6 restarted length", tk, 14);
    maskPin = 1'b0; repeat (4) @(negedge clk);

    // R7: edge trigger
    maskMode = 2'd3; repeat (4) @(negedge clk);
    pollStart(2'b01, 4'd1, t0);
    waitTicks(4);
    chk("R7 busy while armed", pollBusy, 1);
    maskPin = 1'b1;
    waitDone(t0, tk, ns, dms);
    chk("R7 triggered length", tk, 9);
    maskPin = 1'b0; maskMode = 2'd0; repeat (4) @(negedge clk);

    // R10: pressure blocked with current off
    presCurrent = 2'b00;
    pulsePoll(2'b11, 4'd0);
    chk("R10 pressure rejected", pollBusy, 0);
    waitTicks(2);
    chk("R10 still idle", pollBusy, 0);
    presCurrent = 2'b10;
    pollStart(2'b11, 4'd0, t0);
    chk("R10 pressure accepted", pollBusy, 1);
    waitDone(t0, tk, ns, dms);
    chk("R10 pressure channel", rdChan, 3);

    // R11: pen gating
    penGateEn = 1'b1; penDetect = 1'b0; repeat (4) @(negedge clk);
    pollStart(2'b01, 4'd15, t0);
    waitTicks(10);
    chk("R11 held busy", pollBusy, 1);
    penDetect = 1'b1;
    t0 = tickCnt;
    waitDone(t0, tk, ns, dms);
    chk("R11 completes next strobe", tk, 1);
    chk("R11 pen flag", rdPenDown, 1);
    penGateEn = 1'b0; penDetect = 1'b0; repeat (4) @(negedge clk);
    pollStart(2'b10, 4'd0, t0);
    waitDone(t0, tk, ns, dms);
    chk("R8 pen up flag", rdPenDown, 0);
    chk("R8 ungated length", tk, 4);
    penDetect = 1'b1; repeat (4) @(negedge clk);

    // R12: continuous mode
    begin
      int stamps[3];
      int got = 0;
      adcResult = 12'habc; contRate = 3'd2; contSlot = 4'd5;
      wrChanSel = 2'b01; wrDelayCode = 4'd15;
      @(negedge clk); contEn = 1'b1;
      for (int i = 0; i < 5000 && got < 3; i++) begin
        @(negedge clk);
        if (slotValid) begin
          stamps[got] = tickCnt; got++;
          chk("R12 slot number", slotOut, 5);
          chk("R12 result", rdResult, 12'habc);
          chk("R12 poll bit low", pollBusy, 0);
        end
      end
      chk("R12 results seen", got, 3);
      chk("R12 period a", stamps[1] - stamps[0], 6);
      chk("R12 period b", stamps[2] - stamps[1], 6);
      pulsePoll(2'b10, 4'd0);
      chk("R12 poll ignored", pollBusy, 0);
      contEn = 1'b0;
      waitTicks(8);
      pollStart(2'b10, 4'd0, t0);
      chk("R12 poll after exit", pollBusy, 1);
      waitDone(t0, tk, ns, dms);
      chk("R12 poll length after exit", tk, 4);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule